// File: doc/BRIEF.md
# Carry-Less Half-Select Multiplier

This block multiplies two 64-bit polynomials over GF(2). Each input word is 128 bits wide and holds two 64-bit halves. Two bits of an 8-bit immediate choose which half of each word takes part. Partial products are merged with XOR rather than addition, so no carries ever move between bit positions. The 128-bit result is the polynomial product of the two selected halves. Bit i of a half is the coefficient of X^i.

Work enters on a single-cycle valid strobe, and the block accepts a new operation every cycle. The datapath has two register stages:

- **Pick stage.** The chosen halves are registered.
- **Product stage.** The XOR-merged partial-product array is registered into the result.

The result appears two cycles after the inputs are sampled, together with its own valid strobe. The pipeline has no stall and no backpressure. A synchronous active-high reset empties both valid stages.

Top module: `clmul_unit`

## Requirements
- R1: A result with `out_valid` high appears exactly two clock cycles after each cycle in which `in_valid` is sampled high. No result appears in any other cycle. Results leave in the order their inputs arrived.
- R2: While `rst` is high, and in the first cycle after it falls, `out_valid` is low.
- R3: Result bit k equals the XOR, over every pair i+j=k, of (selected first-operand bit i AND selected second-operand bit j).
- R4: Immediate bit 0 picks the half of `in_opa`. A value of 0 selects bits [63:0] and a value of 1 selects bits [127:64]. So immediate 0x00 is low×low and 0x01 is high(opa)×low(opb).
- R5: Immediate bit 4 picks the half of `in_opb`. A value of 0 selects bits [63:0] and a value of 1 selects bits [127:64]. So immediate 0x10 is low(opa)×high(opb) and 0x11 is high×high.
- R6: Immediate bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R7: Result bit 127 is always zero.
- R8: If either selected half is zero, the result is zero.
- R9: If one selected half equals 1 (the constant polynomial), the result is the other selected half, zero-extended to 128 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_opa | input | 128 | First operand word |
| in_opb | input | 128 | Second operand word |
| in_imm | input | 8 | Half-select immediate (bits 0 and 4 used) |
| out_valid | output | 1 | Result strobe |
| out_result | output | 128 | Carry-less product |

## Verification
Every result is due exactly two rising edges after the edge that samples its `in_valid`. The bench stamps each queued expectation with the cycle count at issue. The monitor samples on the falling edge and requires each popped item to arrive in the cycle stamped plus two. Any `out_valid` with an empty queue fails. So does any expectation still queued at the end. This catches lost, extra and reordered results as well as wrong values. Stimulus covers back-to-back issue and issue with idle gaps between operations.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
    localparam int HALF_W_DEF = 64;
    localparam int IMM_W      = 8;
    localparam int SEL_A_BIT  = 0;
    localparam int SEL_B_BIT  = 4;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/clmul_half_pick.sv
module clmul_half_pick
    import clmul_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic [2*HALF_W-1:0] word,
    input  half_e               sel,
    output logic [HALF_W-1:0]   half
);
    always_comb begin
        unique case (sel)
            HALF_LO: half = word[HALF_W-1:0];
            HALF_HI: half = word[2*HALF_W-1:HALF_W];
            default: half = '0;
        endcase
    end
endmodule

// File: rtl/clmul_pp_array.sv
module clmul_pp_array #(
    parameter int HALF_W = clmul_pkg::HALF_W_DEF
) (
    input  logic [HALF_W-1:0]   mul_a,
    input  logic [HALF_W-1:0]   mul_b,
    output logic [2*HALF_W-1:0] prod
);
    localparam int PROD_W = 2 * HALF_W;

    logic [PROD_W-1:0] rows [HALF_W];
    logic [PROD_W-1:0] a_ext;

    assign a_ext = {{HALF_W{1'b0}}, mul_a};

    // one shifted copy of mul_a per set bit of mul_b
    for (genvar j = 0; j < HALF_W; j++) begin : g_row
        assign rows[j] = mul_b[j] ? (a_ext << j) : '0;
    end

    // carry-free merge of the rows
    always_comb begin
        prod = '0;
        for (int j = 0; j < HALF_W; j++) begin
            prod = prod ^ rows[j];
        end
    end
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
    import clmul_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2*HALF_W-1:0] in_opa,
    input  logic [2*HALF_W-1:0] in_opb,
    input  logic [IMM_W-1:0]    in_imm,
    output logic                out_valid,
    output logic [2*HALF_W-1:0] out_result
);
    localparam int PROD_W = 2 * HALF_W;

    half_e             sel_a, sel_b;
    logic [HALF_W-1:0] pick_a, pick_b;
    logic [HALF_W-1:0] a_q, b_q;
    logic              v1_q;
    logic [PROD_W-1:0] prod_c;
    logic [1:0]        rst_age;

    assign sel_a = half_e'(in_imm[SEL_A_BIT]);
    assign sel_b = half_e'(in_imm[SEL_B_BIT]);

    clmul_half_pick #(.HALF_W(HALF_W)) u_pick_a (
        .word (in_opa),
        .sel  (sel_a),
        .half (pick_a)
    );

    clmul_half_pick #(.HALF_W(HALF_W)) u_pick_b (
        .word (in_opb),
        .sel  (sel_b),
        .half (pick_b)
    );

    // pick stage
    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
        end
        if (in_valid) begin
            a_q <= pick_a;
            b_q <= pick_b;
        end
    end

    clmul_pp_array #(.HALF_W(HALF_W)) u_array (
        .mul_a (a_q),
        .mul_b (b_q),
        .prod  (prod_c)
    );

    // product stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= v1_q;
        end
        if (v1_q) begin
            out_result <= prod_c;
        end
    end

    // cycles since reset, saturating, used only by the checks
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_age <= '0;
        end else if (rst_age != 2'd3) begin
            rst_age <= rst_age + 2'd1;
        end
    end

    // R1
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    // R4
    opa_half_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (a_q == ($past(in_imm[SEL_A_BIT]) ?
                              $past(in_opa[PROD_W-1:HALF_W]) :
                              $past(in_opa[HALF_W-1:0]))));

    // R5
    opb_half_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (b_q == ($past(in_imm[SEL_B_BIT]) ?
                              $past(in_opb[PROD_W-1:HALF_W]) :
                              $past(in_opb[HALF_W-1:0]))));

    // R7
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_result[PROD_W-1]);

    // R8
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (v1_q && (a_q == '0 || b_q == '0)) |=> (out_result == '0));

    // R9
    unit_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (v1_q && b_q == HALF_W'(1)) |=>
            (out_result == {{HALF_W{1'b0}}, $past(a_q)}));
endmodule

// File: tb/clmul_unit_tb.sv
module clmul_unit_tb;
    localparam int W  = 64;
    localparam int PW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_opa = '0;
    logic [PW-1:0] in_opb = '0;
    logic [7:0]    in_imm = '0;
    logic          out_valid;
    logic [PW-1:0] out_result;

    always #2.5 clk = ~clk;

    clmul_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_opa     (in_opa),
        .in_opb     (in_opb),
        .in_imm     (in_imm),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    typedef struct {
        logic [PW-1:0] value;
        int            due;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    int   cycle  = 0;
    bit   done   = 1'b0;

    always @(posedge clk) cycle <= cycle + 1;

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [PW-1:0] r = '0;
        for (int i = 0; i < W; i++) begin
            if (y[i]) r = r ^ ({{W{1'b0}}, x} << i);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    // driver: drives at falling edge, one issue per call
    task automatic issue(input logic [PW-1:0] a, input logic [PW-1:0] b,
                         input logic [7:0] imm, input string tag);
        exp_t e;
        logic [W-1:0] ha, hb;
        ha = imm[0] ? a[PW-1:W] : a[W-1:0];
        hb = imm[4] ? b[PW-1:W] : b[W-1:0];
        @(negedge clk);
        in_valid = 1'b1;
        in_opa = a;
        in_opb = b;
        in_imm = imm;
        e.value = ref_mul(ha, hb);
        e.due = cycle + 2;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_opa = {4{32'hDEAD_BEEF}};
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected result", out_result, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cycle == e.due, {e.tag, " R1 timing"}, PW'(cycle), PW'(e.due));
                check(out_result == e.value, e.tag, out_result, e.value);
                check(!out_result[PW-1], "R7 top bit", out_result, '0);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] a, b;
        a = {64'hF0E1_D2C3_B4A5_9687, 64'h0123_4567_89AB_CDEF};
        b = {64'h8000_0000_0000_0003, 64'h1357_9BDF_2468_ACE0};

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2 in reset", PW'(out_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 after reset", PW'(out_valid), '0);

        issue(a, b, 8'h00, "R4 R5 R3 lo-lo");
        issue(a, b, 8'h01, "R4 hi-lo");
        issue(a, b, 8'h10, "R5 lo-hi");
        issue(a, b, 8'h11, "R4 R5 hi-hi");
        idle(3);
        issue(a, b, 8'hEE, "R6 imm EE");
        issue(a, b, 8'hFF, "R6 imm FF");
        issue(a, b, 8'h2E, "R6 imm 2E");
        idle(1);
        issue('0, b, 8'h11, "R8 zero a");
        issue(a, '0, 8'h00, "R8 zero b");
        issue('1, '1, 8'h00, "R3 all ones");
        issue({2{64'h8000_0000_0000_0000}}, {2{64'h8000_0000_0000_0000}}, 8'h11, "R7 X63*X63");
        issue({64'd0, 64'h10}, {64'd0, 64'h100}, 8'h00, "R3 single bits");
        issue(a, {64'd1, 64'd0}, 8'h11, "R9 one hi");
        issue({64'd0, 64'd1}, b, 8'h10, "R9 one lo");
        idle(2);
        for (int n = 0; n < 300; n++) begin
            logic [PW-1:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            issue(ra, rb, 8'($urandom), "R3 random");
            if (n % 7 == 0) idle(n % 3 + 1);
        end
        idle(6);
        check(exp_q.size() == 0, "R1 drained", PW'(exp_q.size()), '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule